// File: doc/BRIEF.md
# Connection Memory Block Fill Engine

This block initialises every word of a switch's connection memory with one value in a single hardware pass. It holds a small control register with a 3-bit fill pattern, a fill-mode enable and a start flag. Once software has set both the enable and the start flag, the engine takes over the memory write port. It writes the pattern into the top three bits of every word, with zeros below it, at ascending addresses. When the last word is written, it clears the start flag on its own.

The memory accepts one write per cycle in which `slot_ok` is high. While the fill runs, the processor's own writes to the connection memory are dropped and the control register is write-protected. When idle, the processor write port passes straight through to the memory port. With every slot granted, a memory of DEPTH words is filled in DEPTH cycles, which fits within two frames when DEPTH is at most two frames' worth of write slots.

Top module: `cmem_fill_top`

## Requirements
- R1: After reset `busy`, `mem_we` and `cfg_rdata` are all 0.
- R2: A control write while idle stores the pattern from `cfg_wdata[9:7]`, the fill enable from bit 11 and the start flag from bit 10. `cfg_rdata` returns them at the same positions, with all other bits 0, from the cycle after the write.
- R3: A start flag written in the same word as a cleared bit 11 is not stored (bit 10 reads back 0), and no fill begins.
- R4: When the stored start flag is 1 and the engine is idle, `busy` is 1 in the next cycle.
- R5: During a fill `mem_we` equals `slot_ok`. The written addresses run 0, 1, … DEPTH-1 in ascending order, with exactly one write per granted slot.
- R6: Every fill write carries the stored pattern in data bits 15:13 and zeros in bits 12:0. Control writes made during the fill change neither the data nor `cfg_rdata`.
- R7: In the cycle after the write to address DEPTH-1, `busy` is 0 and the start flag reads 0, while the enable and pattern bits keep their values.
- R8: Processor writes are dropped while `busy` is 1. While idle, `cpu_we`, `cpu_addr` and `cpu_wdata` appear on the memory port in the same cycle.
- R9: With `slot_ok` held high, `busy` stays 1 for exactly DEPTH cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control write data (pattern 9:7, start 10, enable 11) |
| cfg_rdata | output | 16 | Control register readback |
| cpu_we | input | 1 | Processor write enable to connection memory |
| cpu_addr | input | ADDR_W | Processor write address |
| cpu_wdata | input | 16 | Processor write data |
| slot_ok | input | 1 | Memory accepts a write this cycle |
| mem_we | output | 1 | Connection memory write enable |
| mem_addr | output | ADDR_W | Connection memory write address |
| mem_wdata | output | 16 | Connection memory write data |
| busy | output | 1 | Fill in progress |

## Verification
A corrupted address counter shows up in the very next granted slot as a skipped or repeated `mem_addr`. It also shows as a fill length other than DEPTH cycles. A start flag that fails to clear restarts the fill one cycle after `busy` falls, so `busy` is seen high again at once. A leak in the port multiplexer puts processor data on `mem_wdata` in the same cycle as the offending `cpu_we`. A write-protect fault shows as a changed `cfg_rdata` pattern at the end of the fill.

// File: rtl/cmem_fill_pkg.sv
`timescale 1ns/100ps
// Package: shared control-register layout and engine state type for the
// connection memory fill engine. Assumes a 16-bit control word.
package cmem_fill_pkg;
    localparam int CFG_W     = 16;
    localparam int PAT_W     = 3;
    localparam int PAT_LSB   = 7;
    localparam int START_BIT = 10;
    localparam int EN_BIT    = 11;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fill_state_t;
endpackage

// File: rtl/cmem_fill_ctlreg.sv
`timescale 1ns/100ps
// Control register of the fill engine: holds pattern, fill enable and start
// flag. Writes are ignored while the fill runs; the start flag is stored only
// together with the enable and is cleared by the engine when the fill ends.
module cmem_fill_ctlreg
    import cmem_fill_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  wdata,
    input  logic              busy,
    input  logic              fill_done,
    output logic [PAT_W-1:0]  pattern,
    output logic              start_flag,
    output logic [CFG_W-1:0]  rdata
);
    logic              en_q;
    logic              start_q;
    logic [PAT_W-1:0]  pat_q;
    logic              cfg_unused;

    assign cfg_unused = ^{wdata[CFG_W-1:EN_BIT+1], wdata[PAT_LSB-1:0]};

    // Register update: completion clears start, idle writes load all fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            start_q <= 1'b0;
            pat_q   <= '0;
        end else if (fill_done) begin
            start_q <= 1'b0;
        end else if (wr_en && !busy) begin
            en_q    <= wdata[EN_BIT];
            start_q <= wdata[START_BIT] & wdata[EN_BIT];
            pat_q   <= wdata[PAT_LSB +: PAT_W];
        end
    end

    // Readback assembly at the same bit positions as the write word.
    always_comb begin
        rdata                    = '0;
        rdata[EN_BIT]            = en_q;
        rdata[START_BIT]         = start_q;
        rdata[PAT_LSB +: PAT_W]  = pat_q;
    end

    assign pattern    = pat_q;
    assign start_flag = start_q;
endmodule

// File: rtl/cmem_fill_seq.sv
`timescale 1ns/100ps
// Fill sequencer: on a stored start flag walks an address counter from 0 to
// the last location, advancing once per granted write slot, and pulses
// fill_done on the final write. Assumes DEPTH is a power of two.
module cmem_fill_seq
    import cmem_fill_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_flag,
    input  logic              slot_ok,
    output logic              busy,
    output logic              fill_we,
    output logic [ADDR_W-1:0] fill_addr,
    output logic              fill_done
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    fill_state_t       state_q;
    logic [ADDR_W-1:0] cnt_q;

    assign busy      = (state_q == ST_FILL);
    assign fill_we   = busy && slot_ok;
    assign fill_addr = cnt_q;
    assign fill_done = fill_we && (cnt_q == LAST_ADDR);

    // State and counter: start from idle, step on each granted slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_flag) begin
                    state_q <= ST_FILL;
                    cnt_q   <= '0;
                end
                ST_FILL: if (fill_we) begin
                    if (fill_done) state_q <= ST_IDLE;
                    else           cnt_q   <= cnt_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmem_fill_wrmux.sv
`timescale 1ns/100ps
// Memory write port selector: the fill engine owns the port while busy and
// the processor path is dropped; when idle the processor write passes through.
module cmem_fill_wrmux
    import cmem_fill_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              busy,
    input  logic              fill_we,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [PAT_W-1:0]  pattern,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int ZERO_W = DATA_W - PAT_W;

    logic [DATA_W-1:0] fill_word;

    // Fill word: pattern in the top bits, zeros below.
    generate
        if (ZERO_W > 0) begin : g_wide
            assign fill_word = {pattern, {ZERO_W{1'b0}}};
        end else begin : g_narrow
            assign fill_word = pattern[PAT_W-1 -: DATA_W];
        end
    endgenerate

    // Port ownership selection.
    always_comb begin
        if (busy) begin
            mem_we    = fill_we;
            mem_addr  = fill_addr;
            mem_wdata = fill_word;
        end else begin
            mem_we    = cpu_we;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
        end
    end
endmodule

// File: rtl/cmem_fill_top.sv
`timescale 1ns/100ps
// Connection memory fill engine top: control register, address sequencer and
// write port selector. Assumes the memory takes one write per slot_ok cycle.
module cmem_fill_top
    import cmem_fill_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              slot_ok,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy
);
    logic [PAT_W-1:0]  pattern;
    logic              start_flag;
    logic              fill_we;
    logic              fill_done;
    logic [ADDR_W-1:0] fill_addr;

    cmem_fill_ctlreg u_ctlreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wdata      (cfg_wdata),
        .busy       (busy),
        .fill_done  (fill_done),
        .pattern    (pattern),
        .start_flag (start_flag),
        .rdata      (cfg_rdata)
    );

    cmem_fill_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_flag (start_flag),
        .slot_ok    (slot_ok),
        .busy       (busy),
        .fill_we    (fill_we),
        .fill_addr  (fill_addr),
        .fill_done  (fill_done)
    );

    cmem_fill_wrmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wrmux (
        .busy       (busy),
        .fill_we    (fill_we),
        .fill_addr  (fill_addr),
        .pattern    (pattern),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );
endmodule

// File: rtl/cmem_fill_chk.sv
`timescale 1ns/100ps
// Checker for the fill engine, bound to the top; observes ports only.
module cmem_fill_chk
    import cmem_fill_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              slot_ok,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [15:0]       cfg_rdata
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    p_start_follows_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_rdata[START_BIT]) |=> busy);

    p_start_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[START_BIT] |-> cfg_rdata[EN_BIT]);

    p_no_write_without_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !slot_ok) |-> !mem_we);

    p_addr_ascends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_we && mem_addr != LAST_ADDR) |=>
        (busy && mem_addr == $past(mem_addr) + 1'b1));

    p_low_bits_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_we) |-> (mem_wdata[DATA_W-PAT_W-1:0] == '0));

    p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg_rdata));

    p_end_clears_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_we && mem_addr == LAST_ADDR) |=> (!busy && !cfg_rdata[START_BIT]));
endmodule

bind cmem_fill_top cmem_fill_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .slot_ok   (slot_ok),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .cfg_rdata (cfg_rdata)
);

// File: tb/cmem_fill_top_tb_top.sv
`timescale 1ns/100ps
module cmem_fill_top_tb_top;
    localparam int AW    = 5;
    localparam int DEPTH = 1 << AW;
    localparam logic [15:0] EN  = 16'h0800;
    localparam logic [15:0] STA = 16'h0400;

    // idle pass-through vectors: {addr[4:0], data[15:0]}
    localparam logic [20:0] VEC [6] = '{
        {5'd0,  16'h1234}, {5'd31, 16'hFFFF}, {5'd7, 16'h0001},
        {5'd16, 16'hA5A5}, {5'd3,  16'h0000}, {5'd30, 16'h8000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic slot_ok = 1'b0;
    logic mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic busy;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cmem_fill_top #(.ADDR_W(AW), .DATA_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .slot_ok(slot_ok), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [15:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // slot_mode: 0 always, 1 every other cycle, 2 one in three
    task automatic run_fill(input logic [2:0] pat, input int slot_mode);
        int exp_addr = 0;
        int cyc = 0;
        bit bad_gate = 0;
        bit bad_addr = 0;
        bit bad_data = 0;
        cfg_write(EN | STA | (16'(pat) << 7));
        chk(cfg_rdata == (EN | STA | (16'(pat) << 7)) && !busy, "R2",
            int'(cfg_rdata), int'(EN | STA | (16'(pat) << 7)));
        @(negedge clk);
        chk(busy == 1'b1, "R4", int'(busy), 1);
        while (busy && cyc < 4 * DEPTH) begin
            slot_ok   = (slot_mode == 0) ? 1'b1 :
                        (slot_mode == 1) ? cyc[0] : (cyc % 3 == 0);
            cpu_we    = 1'b1;
            cpu_addr  = AW'(cyc + 9);
            cpu_wdata = 16'h00FF;
            cfg_we    = 1'b1;
            cfg_wdata = 16'h0000;
            #1;
            if (mem_we != slot_ok) bad_gate = 1;
            if (mem_we) begin
                if (int'(mem_addr) != exp_addr) bad_addr = 1;
                if (mem_wdata != {pat, 13'd0}) bad_data = 1;
                exp_addr++;
            end
            cyc++;
            @(negedge clk);
        end
        cpu_we = 1'b0; cfg_we = 1'b0; slot_ok = 1'b0;
        #1;
        chk(!bad_gate, "R5/R8 write gate", int'(bad_gate), 0);
        chk(!bad_addr, "R5 address order", int'(bad_addr), 0);
        chk(!bad_data, "R6 fill word", int'(bad_data), 0);
        chk(exp_addr == DEPTH, "R5 write count", exp_addr, DEPTH);
        if (slot_mode == 0) chk(cyc == DEPTH, "R9 fill cycles", cyc, DEPTH);
        chk(!busy && cfg_rdata == (EN | (16'(pat) << 7)), "R7 start cleared",
            int'(cfg_rdata), int'(EN | (16'(pat) << 7)));
        @(negedge clk);
        chk(!busy, "R7 no restart", int'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(!busy && !mem_we && cfg_rdata == 16'h0, "R1 reset",
            int'({busy, mem_we, cfg_rdata}), 0);

        // R8 idle pass-through, vector table
        foreach (VEC[i]) begin
            @(negedge clk);
            cpu_we = 1'b1; cpu_addr = VEC[i][20:16]; cpu_wdata = VEC[i][15:0];
            #1;
            chk(mem_we && mem_addr == VEC[i][20:16] && mem_wdata == VEC[i][15:0],
                "R8 pass-through", int'({mem_addr, mem_wdata}), int'(VEC[i]));
        end
        @(negedge clk);
        cpu_we = 1'b0;

        // R3 start without enable
        cfg_write(STA | (16'd5 << 7));
        chk(cfg_rdata == (16'd5 << 7), "R3 start dropped", int'(cfg_rdata), int'(16'd5 << 7));
        slot_ok = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !mem_we, "R3 no fill", int'({busy, mem_we}), 0);
        slot_ok = 1'b0;

        // R2 enable only
        cfg_write(EN | (16'd3 << 7) | 16'hF07F);
        chk(cfg_rdata == (EN | (16'd3 << 7)), "R2 readback", int'(cfg_rdata),
            int'(EN | (16'd3 << 7)));
        @(negedge clk);
        chk(!busy, "R4 enable alone idle", int'(busy), 0);

        run_fill(3'd6, 0);
        run_fill(3'd1, 1);
        run_fill(3'd7, 2);

        // R8 after fill, processor path restored
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = 5'd12; cpu_wdata = 16'h5A5A;
        #1;
        chk(mem_we && mem_addr == 5'd12 && mem_wdata == 16'h5A5A, "R8 restored",
            int'(mem_wdata), 16'h5A5A);
        @(negedge clk);
        cpu_we = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule